// File: doc/BRIEF.md
# Rate-Steered Nanosecond System Clock

This block keeps a 64-bit system time counted in nanoseconds, with zero meaning the start of the year 2000. The system time is the sum of a local counter and a software-written offset. The local counter advances by a fixed amount on every enabled tick. The nominal amount is 10 ns, which suits a 100 MHz tick. The low 32 bits of the output wrap roughly every 4.2 s and may be used alone as a short timestamp.

To follow a reference clock elsewhere in the network, the host periodically presents a received reference time on a write strobe. The block subtracts a stored propagation delay from its own system time and compares the result with the received time. The sign of that error selects one of three rates. If the local clock is ahead, it slows down: one tick in every N counts 9 ns. If the local clock is behind, it speeds up: one tick in every N counts 11 ns. A zero error restores the nominal rate. N is programmable. A received time never overwrites the counter. Only an offset write makes the system time step.

Top module: `sys_time_drift_top`

## Requirements
- R1: After reset, `sys_time` reads 0, the offset and delay are 0, the correction period is 4, and the rate is nominal.
- R2: In the nominal rate, each cycle with `tick_en` high raises `sys_time` by 10 on the next cycle. A cycle with `tick_en` low and no offset write leaves `sys_time` unchanged.
- R3: An offset write replaces the offset with `ofs_data`. From the next cycle, `sys_time` equals the local count plus the new offset. This is a step change.
- R4: A received-time write never loads the counter. In the cycle after it, `sys_time` has moved only by that cycle's tick increment.
- R5: If the error (system time − delay − received time, taken as a signed 64-bit value) is greater than 0, the rate becomes slow. The tick that completes each group of N enabled ticks adds 9, and the other ticks add 10.
- R6: If the error is less than 0, the rate becomes fast. The tick that completes each group of N enabled ticks adds 11, and the other ticks add 10.
- R7: An error of exactly 0 restores the nominal rate, in which every tick adds 10.
- R8: A period write sets N from `period_data`, effective from the next cycle. A period of 0 or 1 makes every enabled tick a corrected tick.
- R9: The selected rate stays in force until the next received-time write. That write also restarts the count of enabled ticks toward the next corrected tick. Cycles without `tick_en` do not advance that count.
- R10: The error uses the delay most recently written through `dly_wr`, zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Local time advances this cycle |
| ofs_wr | input | 1 | Load offset strobe |
| ofs_data | input | 64 | New offset value |
| dly_wr | input | 1 | Load propagation-delay strobe |
| dly_data | input | 32 | New propagation delay, ns |
| rx_wr | input | 1 | Received reference time strobe |
| rx_time | input | 64 | Received reference time, ns |
| period_wr | input | 1 | Load correction period strobe |
| period_data | input | 16 | Correction period N in ticks |
| sys_time | output | 64 | Local time plus offset, ns |

## Verification
The hardest situation to reach is a corrected tick landing exactly where R5, R6 and R9 predict. That outcome depends together on the error sign, the period, the restart at each received-time write, and gaps in `tick_en`. None of these can be seen directly at the ports. The directed part therefore builds each received time from the bench's own prediction of the system time minus the delay, plus a chosen small signed error. This forces each rate in turn, with periods of 4 and 0. A long random phase then mixes tick gaps, period changes, offset steps and errors within a few nanoseconds of zero. Every cycle's `sys_time` is compared against the bench model.

// File: rtl/sys_time_pkg.sv
package sys_time_pkg;

    typedef enum logic [1:0] {
        SLEW_NOM  = 2'd0,
        SLEW_SLOW = 2'd1,
        SLEW_FAST = 2'd2
    } slew_e;

endpackage

// File: rtl/st_offset_ext.sv
// Width adapter for the offset register: a narrow offset is zero-extended,
// a wide input is truncated to the stored width.
module st_offset_ext #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    generate
        if (IN_W >= OUT_W) begin : g_trunc
            assign dout = din[OUT_W-1:0];
        end else begin : g_zext
            assign dout = {{(OUT_W-IN_W){1'b0}}, din};
        end
    endgenerate
endmodule

// File: rtl/st_err_cmp.sv
// Signed comparison of delay-corrected local system time against a received time.
module st_err_cmp
    import sys_time_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int DELAY_W = 32
) (
    input  logic [TIME_W-1:0]  local_time,
    input  logic [TIME_W-1:0]  offset,
    input  logic [DELAY_W-1:0] delay,
    input  logic [TIME_W-1:0]  rx_time,
    output slew_e              slew_new
);
    logic [TIME_W-1:0] delay_ext;
    logic [TIME_W-1:0] err;

    st_offset_ext #(.IN_W(DELAY_W), .OUT_W(TIME_W)) dly_ext_i (
        .din  (delay),
        .dout (delay_ext)
    );

    always_comb begin
        err = local_time + offset - delay_ext - rx_time;
        if (err == '0) begin
            slew_new = SLEW_NOM;
        end else if (err[TIME_W-1]) begin
            slew_new = SLEW_FAST;   // behind the reference
        end else begin
            slew_new = SLEW_SLOW;   // ahead of the reference
        end
    end
endmodule

// File: rtl/st_rate_gen.sv
// Picks the per-tick increment and advances the corrected-tick counter.
module st_rate_gen
    import sys_time_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int PER_W   = 16,
    parameter int NOM_INC = 10
) (
    input  logic              tick_en,
    input  logic              restart,
    input  slew_e             slew,
    input  logic [PER_W-1:0]  cnt_q,
    input  logic [PER_W-1:0]  period_q,
    output logic [TIME_W-1:0] inc,
    output logic [PER_W-1:0]  cnt_d
);
    localparam logic [TIME_W-1:0] INC_NOM  = TIME_W'(NOM_INC);
    localparam logic [TIME_W-1:0] INC_SLOW = TIME_W'(NOM_INC - 1);
    localparam logic [TIME_W-1:0] INC_FAST = TIME_W'(NOM_INC + 1);

    logic [PER_W:0] cnt_plus;
    logic           group_end;

    always_comb begin
        cnt_plus  = {1'b0, cnt_q} + 1'b1;
        group_end = (cnt_plus >= {1'b0, period_q});

        if (!tick_en) begin
            inc = '0;
        end else if (group_end && slew == SLEW_SLOW) begin
            inc = INC_SLOW;
        end else if (group_end && slew == SLEW_FAST) begin
            inc = INC_FAST;
        end else begin
            inc = INC_NOM;
        end

        if (restart) begin
            cnt_d = '0;
        end else if (tick_en) begin
            cnt_d = group_end ? '0 : cnt_plus[PER_W-1:0];
        end else begin
            cnt_d = cnt_q;
        end
    end
endmodule

// File: rtl/sys_time_drift_top.sv
module sys_time_drift_top
    import sys_time_pkg::*;
#(
    parameter int TIME_W     = 64,
    parameter int OFFSET_W   = 64,
    parameter int DELAY_W    = 32,
    parameter int PER_W      = 16,
    parameter int NOM_INC    = 10,
    parameter int DEF_PERIOD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                ofs_wr,
    input  logic [OFFSET_W-1:0] ofs_data,
    input  logic                dly_wr,
    input  logic [DELAY_W-1:0]  dly_data,
    input  logic                rx_wr,
    input  logic [TIME_W-1:0]   rx_time,
    input  logic                period_wr,
    input  logic [PER_W-1:0]    period_data,
    output logic [TIME_W-1:0]   sys_time
);
    typedef struct packed {
        logic [TIME_W-1:0]  local_t;
        logic [TIME_W-1:0]  offset;
        logic [DELAY_W-1:0] delay;
        logic [PER_W-1:0]   period;
        logic [PER_W-1:0]   cnt;
        slew_e              slew;
    } state_t;

    state_t st_q, st_d;

    logic [TIME_W-1:0] ofs_ext;
    logic [TIME_W-1:0] inc;
    logic [PER_W-1:0]  cnt_next;
    slew_e             slew_new;

    st_offset_ext #(.IN_W(OFFSET_W), .OUT_W(TIME_W)) ofs_ext_i (
        .din  (ofs_data),
        .dout (ofs_ext)
    );

    st_err_cmp #(.TIME_W(TIME_W), .DELAY_W(DELAY_W)) err_i (
        .local_time (st_q.local_t),
        .offset     (st_q.offset),
        .delay      (st_q.delay),
        .rx_time    (rx_time),
        .slew_new   (slew_new)
    );

    st_rate_gen #(.TIME_W(TIME_W), .PER_W(PER_W), .NOM_INC(NOM_INC)) rate_i (
        .tick_en  (tick_en),
        .restart  (rx_wr),
        .slew     (st_q.slew),
        .cnt_q    (st_q.cnt),
        .period_q (st_q.period),
        .inc      (inc),
        .cnt_d    (cnt_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.local_t = st_q.local_t + inc;
        st_d.cnt     = cnt_next;
        if (ofs_wr)    st_d.offset = ofs_ext;
        if (dly_wr)    st_d.delay  = dly_data;
        if (period_wr) st_d.period = period_data;
        if (rx_wr)     st_d.slew   = slew_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.local_t <= '0;
            st_q.offset  <= '0;
            st_q.delay   <= '0;
            st_q.period  <= PER_W'(DEF_PERIOD);
            st_q.cnt     <= '0;
            st_q.slew    <= SLEW_NOM;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_time = st_q.local_t + st_q.offset;

endmodule

// File: rtl/sys_time_drift_chk.sv
module sys_time_drift_chk
    import sys_time_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int NOM_INC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              ofs_wr,
    input logic              rx_wr,
    input slew_e             slew,
    input logic [TIME_W-1:0] sys_time
);
    localparam logic [TIME_W-1:0] N_INC = TIME_W'(NOM_INC);

    logic [TIME_W-1:0] prev_q;
    logic [TIME_W-1:0] delta;

    always_ff @(posedge clk) prev_q <= sys_time;
    assign delta = sys_time - prev_q;

    // R2: nominal rate advances exactly one nominal step
    a_r2_nominal_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !ofs_wr && slew == SLEW_NOM) |=> (delta == N_INC));

    // R2: no tick and no offset write holds the time
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ofs_wr) |=> (delta == '0));

    // R4: a received time alone never moves the counter
    a_r4_rx_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && !tick_en && !ofs_wr) |=> (delta == '0));

    // R5: slow rate steps by nominal or nominal minus one
    a_r5_slow_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !ofs_wr && slew == SLEW_SLOW) |=> (delta == N_INC || delta == N_INC - 1'b1));

    // R6: fast rate steps by nominal or nominal plus one
    a_r6_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !ofs_wr && slew == SLEW_FAST) |=> (delta == N_INC || delta == N_INC + 1'b1));
endmodule

bind sys_time_drift_top sys_time_drift_chk #(.TIME_W(TIME_W), .NOM_INC(NOM_INC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ofs_wr   (ofs_wr),
    .rx_wr    (rx_wr),
    .slew     (st_q.slew),
    .sys_time (sys_time)
);

// File: tb/sys_time_drift_tb.sv
module sys_time_drift_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        ofs_wr = 1'b0;
    logic [63:0] ofs_data = '0;
    logic        dly_wr = 1'b0;
    logic [31:0] dly_data = '0;
    logic        rx_wr = 1'b0;
    logic [63:0] rx_time = '0;
    logic        period_wr = 1'b0;
    logic [15:0] period_data = '0;
    logic [63:0] sys_time;

    int checks = 0;
    int failures = 0;

    // bench model state
    logic [63:0] m_local = '0;
    logic [63:0] m_off = '0;
    logic [63:0] m_dly = '0;
    int          m_per = 4;
    int          m_cnt = 0;
    int          m_mode = 0;   // 0 nominal, 1 slow, 2 fast

    always #4 clk = ~clk;   // 125 MHz

    sys_time_drift_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .ofs_wr(ofs_wr), .ofs_data(ofs_data),
        .dly_wr(dly_wr), .dly_data(dly_data),
        .rx_wr(rx_wr), .rx_time(rx_time),
        .period_wr(period_wr), .period_data(period_data),
        .sys_time(sys_time)
    );

    function automatic logic [63:0] m_sys();
        return m_local + m_off;
    endfunction

    function automatic int mode_of(logic [63:0] rt);
        logic [63:0] e;
        e = m_local + m_off - m_dly - rt;
        if (e == 64'd0) return 0;
        return e[63] ? 2 : 1;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: sys_time actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(bit te, bit ow, logic [63:0] od, bit dw, logic [31:0] dd,
                       bit rw, logic [63:0] rt, bit pw, logic [15:0] pd, string tag);
        bit last;
        int inc;
        tick_en = te; ofs_wr = ow; ofs_data = od; dly_wr = dw; dly_data = dd;
        rx_wr = rw; rx_time = rt; period_wr = pw; period_data = pd;
        last = (m_cnt + 1 >= m_per);
        inc  = !te ? 0 : (last && m_mode == 1) ? 9 : (last && m_mode == 2) ? 11 : 10;
        if (rw) m_mode = mode_of(rt);
        if (rw) m_cnt = 0;
        else if (te) m_cnt = last ? 0 : m_cnt + 1;
        m_local = m_local + 64'(inc);
        if (ow) m_off = od;
        if (dw) m_dly = {32'd0, dd};
        if (pw) m_per = int'(pd);
        @(posedge clk);
        @(negedge clk);
        check(tag, sys_time, m_sys());
    endtask

    task automatic tick(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rx_err(longint err, string tag);
        cyc(1, 0, 0, 0, 0, 1, m_sys() - m_dly - 64'(err), 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset value", sys_time, 64'd0);

        tick(5, "R1 R2 nominal tick");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 no tick hold");
        cyc(1, 1, 64'd1000, 0, 0, 0, 0, 0, 0, "R3 offset step");
        cyc(0, 1, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, 0, 0, "R3 large offset");
        cyc(0, 0, 0, 1, 32'd50, 0, 0, 0, 0, "R10 delay write");

        cyc(0, 0, 0, 0, 0, 1, m_sys() - m_dly - 64'd7, 0, 0, "R4 rx no load");
        tick(9, "R5 slow rate");
        rx_err(-3, "R6 fast entry");
        tick(9, "R6 fast rate");
        rx_err(0, "R7 zero error");
        tick(6, "R7 nominal restored");
        cyc(1, 0, 0, 0, 0, 1, m_sys(), 0, 0, "R10 delay makes error negative");
        tick(5, "R10 fast via delay");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 16'd0, "R8 period zero");
        rx_err(12, "R8 slow entry");
        tick(4, "R8 every tick corrected");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 16'd3, "R8 period three");
        rx_err(-1, "R9 fast entry");
        for (int i = 0; i < 12; i++) cyc(i % 3 != 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 gaps keep count");

        for (int i = 0; i < 4000; i++) begin
            bit te, ow, dw, rw, pw;
            int r;
            te = ($urandom % 4) != 0;
            ow = ($urandom % 60) == 0;
            dw = ($urandom % 80) == 0;
            rw = ($urandom % 12) == 0;
            pw = ($urandom % 70) == 0;
            r  = int'($urandom % 11) - 5;
            cyc(te, ow, {$urandom, $urandom}, dw, $urandom % 1000,
                rw, m_sys() - m_dly - 64'(longint'(r)), pw, 16'($urandom % 6),
                "R9 random persistence");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule